// File: doc/BRIEF.md
# Aliased Set/Clear Control Register File

This block holds the 8-bit control and status registers that a USB transceiver link interface exposes to its controller. A simple synchronous register bus reaches them: an address, a flag that picks the extended address space, write data, a write strobe, a read strobe and registered read data. Every control register is also driven out in parallel so that the surrounding logic can use its contents directly.

Each writable register has three consecutive addresses. The first replaces the whole register. The second ORs the bus pattern into it. The third clears each bit that is 1 in the bus pattern. The controller can therefore change single bits without a read-modify-write. Identification bytes and the interrupt status, latch and debug bytes can only be read. The interrupt and debug bytes arrive as inputs from logic outside this block. When the extended flag is high the address is a full 8 bits: its lower quarter repeats the immediate map, and the rest reads as zero.

Top module: `link_ctrl_regs`

## Requirements
- R1: While reset is asserted, the outputs settle to these defaults: funcCtrl 41h, ifaceCtrl 00h, otgCtrl 06h, riseIntEn 1Fh, fallIntEn 1Fh, scratchOut 00h, pwrCtrl 00h, and rdData 00h.
- R2: Reads at immediate addresses 00h, 01h, 02h and 03h return the low and high vendor ID bytes and then the low and high product ID bytes, which are parameter constants. Writes to these addresses change nothing.
- R3: A write at a register's base address loads wrData into all eight bits.
- R4: A write at base+1 loads the old value OR wrData.
- R5: A write at base+2 loads the old value AND NOT wrData.
- R6: A read at any of a register's three addresses returns the same current value.
- R7: Reads at 13h, 14h and 15h return the intStatus, intLatch and dbgVal inputs. Writes to these addresses change nothing.
- R8: Addresses 19h through 3Ch read 00h, and writes to them change nothing. This range includes the escape address 2Fh and the vendor-specific range 30h through 3Ch.
- R9: The power control register uses bases 3Dh/3Eh/3Fh for write, set and clear.
- R10: With extSel high, addresses 00h through 3Fh reach the same registers as the immediate map. Addresses 40h through FFh read 00h, and writes to them change nothing.
- R11: A write takes effect on the clock edge where wrEn is high. rdData is loaded on the edge where rdEn is high and holds its value otherwise. A read on the same edge as a write returns the value from before the write.
- R12: The control registers have these base addresses: funcCtrl 04h, ifaceCtrl 07h, otgCtrl 0Ah, riseIntEn 0Dh, fallIntEn 10h, scratchOut 16h.
- R13: With extSel low, only regAddr bits 5:0 are decoded, and bits 7:6 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| regAddr | input | 8 | Register address |
| extSel | input | 1 | Selects the extended 8-bit address space |
| wrData | input | 8 | Write data or set/clear mask |
| wrEn | input | 1 | Write strobe |
| rdEn | input | 1 | Read strobe |
| intStatus | input | 8 | Interrupt status byte to read back |
| intLatch | input | 8 | Interrupt latch byte to read back |
| dbgVal | input | 8 | Debug byte to read back |
| rdData | output | 8 | Registered read data |
| funcCtrl | output | 8 | Function control contents |
| ifaceCtrl | output | 8 | Interface control contents |
| otgCtrl | output | 8 | OTG control contents |
| riseIntEn | output | 8 | Rising-edge interrupt enable contents |
| fallIntEn | output | 8 | Falling-edge interrupt enable contents |
| scratchOut | output | 8 | Scratch contents |
| pwrCtrl | output | 8 | Power control contents |

## Verification
The properties assume that every bus input is known and stable at each rising edge, and that the read strobe and write strobe may be high together. They also treat the alias behaviour of an address as fixed by its decode, so the set and clear checks refer to the scratch triplet only. The stimulus changes inputs only on falling edges, raises each strobe for exactly one cycle, and holds the interrupt and debug inputs steady around every read that returns them.

// File: rtl/lcr_pkg.sv
package lcr_pkg;
  localparam int IMM_AW = 6;
  localparam int EXT_AW = 8;
  localparam int NUM_RW = 7;
  localparam int NUM_RO = 7;

  typedef enum logic [1:0] {
    OP_WRITE = 2'd0,
    OP_SET   = 2'd1,
    OP_CLEAR = 2'd2
  } wrOp_e;

  typedef struct packed {
    logic [NUM_RW-1:0] rwWr;
    wrOp_e             op;
    logic [NUM_RW-1:0] rwRd;
    logic [NUM_RO-1:0] roRd;
    logic              rdStrobe;
  } strobes_t;

  // base address of each write/set/clear triplet
  function automatic logic [IMM_AW-1:0] rwBase(input int idx);
    case (idx)
      0:       return 6'h04;
      1:       return 6'h07;
      2:       return 6'h0A;
      3:       return 6'h0D;
      4:       return 6'h10;
      5:       return 6'h16;
      default: return 6'h3D;
    endcase
  endfunction

  // address of each read-only byte
  function automatic logic [IMM_AW-1:0] roAddr(input int idx);
    case (idx)
      0:       return 6'h00;
      1:       return 6'h01;
      2:       return 6'h02;
      3:       return 6'h03;
      4:       return 6'h13;
      5:       return 6'h14;
      default: return 6'h15;
    endcase
  endfunction

  function automatic logic [7:0] rwDefault(input int idx);
    case (idx)
      0:       return 8'h41;
      2:       return 8'h06;
      3:       return 8'h1F;
      4:       return 8'h1F;
      default: return 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/lcr_decode.sv
module lcr_decode
  import lcr_pkg::*;
(
  input  logic [EXT_AW-1:0] regAddr,
  input  logic              extSel,
  input  logic              wrEn,
  input  logic              rdEn,
  output strobes_t          strb
);
  logic              inRange;
  logic [IMM_AW-1:0] immA;
  logic [1:0]        opBits;

  assign immA    = regAddr[IMM_AW-1:0];
  assign inRange = !extSel || (regAddr[EXT_AW-1:IMM_AW] == '0);

  always_comb begin
    logic [IMM_AW-1:0] off;
    logic              hit;
    opBits = 2'd0;
    strb.rwWr = '0;
    strb.rwRd = '0;
    for (int i = 0; i < NUM_RW; i++) begin
      off = immA - rwBase(i);
      hit = inRange && (immA >= rwBase(i)) && (off < IMM_AW'(3));
      strb.rwWr[i] = wrEn && hit;
      strb.rwRd[i] = rdEn && hit;
      if (hit) opBits = off[1:0];
    end
    strb.op = wrOp_e'(opBits);
    for (int j = 0; j < NUM_RO; j++) begin
      strb.roRd[j] = rdEn && inRange && (immA == roAddr(j));
    end
    strb.rdStrobe = rdEn;
  end
endmodule

// File: rtl/lcr_datapath.sv
module lcr_datapath
  import lcr_pkg::*;
#(
  parameter int          DATA_W     = 8,
  parameter logic [15:0] VENDOR_ID  = 16'hA5C3,
  parameter logic [15:0] PRODUCT_ID = 16'h7E21
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  strobes_t                       strb,
  input  logic [DATA_W-1:0]              wrData,
  input  logic [DATA_W-1:0]              intStatus,
  input  logic [DATA_W-1:0]              intLatch,
  input  logic [DATA_W-1:0]              dbgVal,
  output logic [NUM_RW-1:0][DATA_W-1:0]  rwQ,
  output logic [DATA_W-1:0]              rdData
);
  logic [NUM_RO-1:0][DATA_W-1:0] roVal;
  logic [DATA_W-1:0]             rdMux;

  for (genvar g = 0; g < NUM_RW; g++) begin : gRw
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        rwQ[g] <= DATA_W'(rwDefault(g));
      end else if (strb.rwWr[g]) begin
        case (strb.op)
          OP_SET:   rwQ[g] <= rwQ[g] | wrData;
          OP_CLEAR: rwQ[g] <= rwQ[g] & ~wrData;
          default:  rwQ[g] <= wrData;
        endcase
      end
    end
  end

  assign roVal[0] = DATA_W'(VENDOR_ID[7:0]);
  assign roVal[1] = DATA_W'(VENDOR_ID[15:8]);
  assign roVal[2] = DATA_W'(PRODUCT_ID[7:0]);
  assign roVal[3] = DATA_W'(PRODUCT_ID[15:8]);
  assign roVal[4] = intStatus;
  assign roVal[5] = intLatch;
  assign roVal[6] = dbgVal;

  always_comb begin
    rdMux = '0;
    for (int i = 0; i < NUM_RW; i++) if (strb.rwRd[i]) rdMux |= rwQ[i];
    for (int j = 0; j < NUM_RO; j++) if (strb.roRd[j]) rdMux |= roVal[j];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              rdData <= '0;
    else if (strb.rdStrobe) rdData <= rdMux;
  end
endmodule

// File: rtl/link_ctrl_regs.sv
module link_ctrl_regs
  import lcr_pkg::*;
#(
  parameter logic [15:0] VENDOR_ID  = 16'hA5C3,
  parameter logic [15:0] PRODUCT_ID = 16'h7E21
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [7:0] regAddr,
  input  logic       extSel,
  input  logic [7:0] wrData,
  input  logic       wrEn,
  input  logic       rdEn,
  input  logic [7:0] intStatus,
  input  logic [7:0] intLatch,
  input  logic [7:0] dbgVal,
  output logic [7:0] rdData,
  output logic [7:0] funcCtrl,
  output logic [7:0] ifaceCtrl,
  output logic [7:0] otgCtrl,
  output logic [7:0] riseIntEn,
  output logic [7:0] fallIntEn,
  output logic [7:0] scratchOut,
  output logic [7:0] pwrCtrl
);
  strobes_t                 strb;
  logic [NUM_RW-1:0][7:0]   rwQ;

  lcr_decode u_decode (
    .regAddr (regAddr),
    .extSel  (extSel),
    .wrEn    (wrEn),
    .rdEn    (rdEn),
    .strb    (strb)
  );

  lcr_datapath #(
    .DATA_W     (8),
    .VENDOR_ID  (VENDOR_ID),
    .PRODUCT_ID (PRODUCT_ID)
  ) u_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .wrData    (wrData),
    .intStatus (intStatus),
    .intLatch  (intLatch),
    .dbgVal    (dbgVal),
    .rwQ       (rwQ),
    .rdData    (rdData)
  );

  assign funcCtrl   = rwQ[0];
  assign ifaceCtrl  = rwQ[1];
  assign otgCtrl    = rwQ[2];
  assign riseIntEn  = rwQ[3];
  assign fallIntEn  = rwQ[4];
  assign scratchOut = rwQ[5];
  assign pwrCtrl    = rwQ[6];
endmodule

// File: rtl/link_ctrl_regs_chk.sv
module link_ctrl_regs_chk (
  input logic       clk,
  input logic       rstN,
  input logic [7:0] regAddr,
  input logic       extSel,
  input logic [7:0] wrData,
  input logic       wrEn,
  input logic       rdEn,
  input logic [7:0] rdData,
  input logic [7:0] funcCtrl,
  input logic [7:0] ifaceCtrl,
  input logic [7:0] otgCtrl,
  input logic [7:0] riseIntEn,
  input logic [7:0] fallIntEn,
  input logic [7:0] scratchOut,
  input logic [7:0] pwrCtrl
);
  logic [55:0] allOut;
  assign allOut = {funcCtrl, ifaceCtrl, otgCtrl, riseIntEn, fallIntEn, scratchOut, pwrCtrl};

  AST_RESET_DEFAULTS: assert property (@(posedge clk)
    !rstN |=> (funcCtrl == 8'h41 && otgCtrl == 8'h06 && riseIntEn == 8'h1F && scratchOut == 8'h00 && rdData == 8'h00)); // R1

  AST_SCRATCH_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !extSel && regAddr[5:0] == 6'h16) |=> scratchOut == $past(wrData)); // R3

  AST_SCRATCH_SET: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !extSel && regAddr[5:0] == 6'h17) |=> scratchOut == ($past(scratchOut) | $past(wrData))); // R4

  AST_SCRATCH_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !extSel && regAddr[5:0] == 6'h18) |=> scratchOut == ($past(scratchOut) & ~$past(wrData))); // R5

  AST_RO_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !extSel && (regAddr[5:0] inside {[6'h00:6'h03], [6'h13:6'h15]})) |=> $stable(allOut)); // R7

  AST_RESERVED_READ_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && !extSel && (regAddr[5:0] inside {[6'h19:6'h3C]})) |=> rdData == 8'h00); // R8

  AST_EXT_HIGH_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && extSel && regAddr >= 8'h40) |=> $stable(allOut)); // R10

  AST_EXT_HIGH_READ_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && extSel && regAddr >= 8'h40) |=> rdData == 8'h00); // R10

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !rdEn |=> $stable(rdData)); // R11

  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |=> $stable(allOut)); // R11
endmodule

bind link_ctrl_regs link_ctrl_regs_chk i_chk (.*);

// File: tb/test_link_ctrl_regs.sv
module test_link_ctrl_regs;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] regAddr = '0;
  logic       extSel = 1'b0;
  logic [7:0] wrData = '0;
  logic       wrEn = 1'b0;
  logic       rdEn = 1'b0;
  logic [7:0] intStatus = 8'h3C;
  logic [7:0] intLatch = 8'hC5;
  logic [7:0] dbgVal = 8'h9A;
  logic [7:0] rdData, funcCtrl, ifaceCtrl, otgCtrl, riseIntEn, fallIntEn, scratchOut, pwrCtrl;

  int nChecks = 0;
  int nErrors = 0;
  bit finished = 0;

  logic [7:0] model [7];
  logic [7:0] bases [7] = '{8'h04, 8'h07, 8'h0A, 8'h0D, 8'h10, 8'h16, 8'h3D};
  logic [7:0] idBytes [4] = '{8'hC3, 8'hA5, 8'h21, 8'h7E};

  link_ctrl_regs i_link_ctrl_regs (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] outOf(input int i);
    case (i)
      0: return funcCtrl;
      1: return ifaceCtrl;
      2: return otgCtrl;
      3: return riseIntEn;
      4: return fallIntEn;
      5: return scratchOut;
      default: return pwrCtrl;
    endcase
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErrors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic checkOuts(input string req);
    for (int i = 0; i < 7; i++) check(req, outOf(i), model[i]);
  endtask

  task automatic doWrite(input logic [7:0] a, input bit ext, input logic [7:0] d);
    @(negedge clk);
    regAddr = a; extSel = ext; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0; extSel = 1'b0;
  endtask

  task automatic doRead(input logic [7:0] a, input bit ext, output logic [7:0] q);
    @(negedge clk);
    regAddr = a; extSel = ext; rdEn = 1'b1;
    @(negedge clk);
    rdEn = 1'b0; extSel = 1'b0;
    q = rdData;
  endtask

  task automatic testReset();
    model = '{8'h41, 8'h00, 8'h06, 8'h1F, 8'h1F, 8'h00, 8'h00};
    checkOuts("R1 defaults");
    check("R1 rdData", rdData, 8'h00);
  endtask

  task automatic testTriplets();
    logic [7:0] q;
    for (int i = 0; i < 7; i++) begin
      doWrite(bases[i], 0, 8'h5A);
      model[i] = 8'h5A;
      check(i == 6 ? "R9 write" : "R3 R12 write", outOf(i), model[i]);
      doWrite(bases[i] + 8'd1, 0, 8'h81);
      model[i] = 8'hDB;
      check(i == 6 ? "R9 set" : "R4 set", outOf(i), model[i]);
      doWrite(bases[i] + 8'd2, 0, 8'h0A);
      model[i] = 8'hD1;
      check(i == 6 ? "R9 clear" : "R5 clear", outOf(i), model[i]);
      for (int k = 0; k < 3; k++) begin
        doRead(bases[i] + 8'(k), 0, q);
        check("R6 alias read", q, model[i]);
      end
    end
    checkOuts("R3 no cross-talk");
  endtask

  task automatic testIdBytes();
    logic [7:0] q;
    for (int i = 0; i < 4; i++) begin
      doWrite(8'(i), 0, 8'hFF);
      checkOuts("R2 write ignored");
      doRead(8'(i), 0, q);
      check("R2 id byte", q, idBytes[i]);
    end
  endtask

  task automatic testStatusBytes();
    logic [7:0] q;
    doRead(8'h13, 0, q); check("R7 status", q, 8'h3C);
    doRead(8'h14, 0, q); check("R7 latch", q, 8'hC5);
    doRead(8'h15, 0, q); check("R7 debug", q, 8'h9A);
    intStatus = 8'h07;
    doRead(8'h13, 0, q); check("R7 status follows", q, 8'h07);
    doWrite(8'h13, 0, 8'hFF);
    doWrite(8'h15, 0, 8'h00);
    checkOuts("R7 write ignored");
  endtask

  task automatic testReserved();
    logic [7:0] q;
    logic [7:0] addrs [5] = '{8'h19, 8'h2E, 8'h2F, 8'h30, 8'h3C};
    for (int i = 0; i < 5; i++) begin
      doWrite(addrs[i], 0, 8'hFF);
      checkOuts("R8 write ignored");
      doRead(addrs[i], 0, q);
      check("R8 reads zero", q, 8'h00);
    end
  endtask

  task automatic testExtended();
    logic [7:0] q;
    doRead(8'h16, 1, q); check("R10 ext mirror read", q, model[5]);
    doWrite(8'h04, 1, 8'h33); model[0] = 8'h33;
    check("R10 ext mirror write", funcCtrl, 8'h33);
    doRead(8'h02, 1, q); check("R10 ext id", q, idBytes[2]);
    doWrite(8'h56, 1, 8'hFF);
    doWrite(8'h44, 1, 8'hFF);
    doWrite(8'hFF, 1, 8'h00);
    checkOuts("R10 high ext write ignored");
    doRead(8'h40, 1, q); check("R10 ext 40h", q, 8'h00);
    doRead(8'hD6, 1, q); check("R10 ext D6h", q, 8'h00);
    doRead(8'hD6, 0, q); check("R13 upper bits ignored", q, model[5]);
    doWrite(8'hC7, 0, 8'h66); model[1] = 8'h66;
    check("R13 upper bits write", ifaceCtrl, 8'h66);
  endtask

  task automatic testTiming();
    logic [7:0] q;
    doRead(8'h16, 0, q);
    doWrite(8'h16, 0, 8'hE4); model[5] = 8'hE4;
    check("R11 rdData holds", rdData, q);
    @(negedge clk);
    regAddr = 8'h16; wrData = 8'h18; wrEn = 1'b1; rdEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0; rdEn = 1'b0;
    check("R11 read-before-write", rdData, 8'hE4);
    check("R11 write same edge", scratchOut, 8'h18);
    model[5] = 8'h18;
    checkOuts("R11 final");
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      nErrors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    testTriplets();
    testIdBytes();
    testStatusBytes();
    testReserved();
    testExtended();
    testTiming();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  end
endmodule